// File: doc/BRIEF.md
# Redundant-Unit Role Arbiter

This block assigns an operating role to each processor of a small redundant group. Each unit is reported as Master, Checker or Off-Line, and no unit has a fixed role. A unit becomes Master by claiming the role first, and it keeps the role for as long as it stays operational. When several units claim on the same sampled clock edge, the unit with the lowest hardwired node ID wins, so the choice never depends on a race between near-simultaneous requests.

Claim requests and operational flags arrive from outside the clock domain. They pass through a synchronizer before the arbiter sees them. A unit that rejoins the group, whatever its ID, comes back as a Checker and cannot take the role from the current holder. A parameter selects a restricted variant for groups in which running on a single unit is not allowed. In that variant only units 0 and 1 can become Master, so selection only has to decide between two candidates.

Top module: `role_arbiter`

## Requirements
- R1: Unit i's role sits in `role[2i+1:2i]`, coded 2'b00 Off-Line, 2'b01 Checker and 2'b10 Master. A unit whose synchronized operational flag is low reads Off-Line, and an operational unit that is not Master reads Checker. A change of `unit_up` shows on `role` after SYNC_STAGES rising edges (two by default).
- R2: At most one unit reads Master at any time. `master_valid` is high only while a Master is held, that Master is operational and at least two units are operational.
- R3: If no Master is held, an operational, master-capable unit with its claim set can be granted. Among such units the one with the lowest `node_id` value wins, and equal IDs go to the lower index. A claim applied before edge k shows as Master after edge k+SYNC_STAGES (the third edge by default).
- R4: A Master keeps the role while it stays operational. A claim from a unit with a lower ID, including a unit that has just rejoined, has no effect on `role`.
- R5: When the Master's operational flag drops, the unit reads Off-Line after SYNC_STAGES edges. The held mastership is cleared one edge later, and a new Master is chosen among the remaining claimants one edge after that (the fourth edge by default).
- R6: No mastership is granted while fewer than two units are operational.
- R7: With RESTRICTED set, only units 0 and 1 are master-capable. A claim from any other unit is ignored.
- R8: While `rst_n` is low, every unit reads Off-Line and `master_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| claim_req | input | N_UNITS | Per-unit request to take the Master role |
| unit_up | input | N_UNITS | Per-unit operational flag |
| node_id | input | N_UNITS*ID_W | Static per-unit IDs, unit i at bits [i*ID_W +: ID_W] |
| role | output | 2*N_UNITS | Per-unit role code |
| master_valid | output | 1 | A valid Master exists and the group has a quorum |

## Verification
Results are due at fixed edge counts after the inputs change:
- A change of the operational flags shows on `role` after two rising edges.
- A grant shows after three edges.
- A replacement Master after a holder drops out shows after four edges.

The driver changes the inputs just after a falling edge. It queues each expected role vector tagged with the exact edge count at which that value is due, and the monitor compares the outputs one time unit after the falling edge of that cycle. Some entries check the previous value one edge before the change is due, so a result that arrives early or late is also reported.

// File: rtl/role_arb_pkg.sv
package role_arb_pkg;

   localparam int ROLE_W = 2;

   typedef enum logic [ROLE_W-1:0] {
      ROLE_OFF = 2'b00,
      ROLE_CHK = 2'b01,
      ROLE_MST = 2'b10
   } role_e;

endpackage

// File: rtl/role_sync.sv
module role_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0][WIDTH-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/role_pick.sv
module role_pick #(
   parameter int  N_CAND     = 3,
   parameter int  ID_W       = 4,
   parameter int  IDX_W      = 2,
   parameter bit  RESTRICTED = 1'b0
) (
   input  logic [N_CAND-1:0]      elig,
   input  logic [N_CAND*ID_W-1:0] ids,
   output logic                   found,
   output logic [IDX_W-1:0]       best
);

   generate
      if (RESTRICTED) begin : g_pair
         // two-candidate variant: a single compare decides
         logic [ID_W-1:0] id_a, id_b;
         assign id_a = ids[0 +: ID_W];
         assign id_b = ids[ID_W +: ID_W];
         always_comb begin
            found = elig[0] | elig[1];
            if (elig[0] && elig[1])
               best = (id_b < id_a) ? IDX_W'(1) : IDX_W'(0);
            else if (elig[1])
               best = IDX_W'(1);
            else
               best = IDX_W'(0);
         end
      end else begin : g_scan
         logic [ID_W-1:0] best_id;
         always_comb begin
            found   = 1'b0;
            best    = '0;
            best_id = '0;
            for (int i = 0; i < N_CAND; i++) begin
               if (elig[i] && (!found || ids[i*ID_W +: ID_W] < best_id)) begin
                  found   = 1'b1;
                  best    = IDX_W'(i);
                  best_id = ids[i*ID_W +: ID_W];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/role_hold.sv
module role_hold #(
   parameter int N_UNITS = 3,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_UNITS-1:0] up_s,
   input  logic               quorum,
   input  logic               found,
   input  logic [IDX_W-1:0]   best,
   output logic               held,
   output logic [IDX_W-1:0]   holder
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held   <= 1'b0;
         holder <= '0;
      end else if (held) begin
         if (!up_s[holder]) held <= 1'b0;
      end else if (found && quorum) begin
         held   <= 1'b1;
         holder <= best;
      end
   end

   // R4: an operational holder is never displaced
   p_keep_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (held && up_s[holder]) |=> (held && $stable(holder)));

   // R5: a holder that went offline loses the role on the next edge
   p_drop_offline_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !up_s[holder]) |=> !held);

   // R6: no grant without two operational units
   p_no_grant_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !quorum) |=> !held);

endmodule

// File: rtl/role_arbiter.sv
module role_arbiter #(
   parameter int N_UNITS     = 3,
   parameter int ID_W        = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit RESTRICTED  = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_UNITS-1:0]        claim_req,
   input  logic [N_UNITS-1:0]        unit_up,
   input  logic [N_UNITS*ID_W-1:0]   node_id,
   output logic [2*N_UNITS-1:0]      role,
   output logic                      master_valid
);
   import role_arb_pkg::*;

   localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;
   localparam int CNT_W  = $clog2(N_UNITS + 1);
   localparam int N_CAND = RESTRICTED ? 2 : N_UNITS;

   generate
      if (N_UNITS < 2) begin : g_bad_units
         $error("role_arbiter: N_UNITS must be at least 2");
      end
      if (RESTRICTED && N_UNITS < 3) begin : g_bad_restrict
         $error("role_arbiter: restricted mode needs at least 3 units");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("role_arbiter: SYNC_STAGES must be at least 1");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("role_arbiter: ID_W must be at least 1");
      end
   endgenerate

   logic [N_UNITS-1:0] claim_s, up_s, capable, elig;
   logic [CNT_W-1:0]   up_cnt;
   logic               quorum, found, held;
   logic [IDX_W-1:0]   best, holder;
   logic [N_UNITS-1:0] mst_vec;
   role_e              role_v [N_UNITS];

   role_sync #(.WIDTH(N_UNITS), .STAGES(SYNC_STAGES)) u_sync_claim (
      .clk(clk), .rst_n(rst_n), .d(claim_req), .q(claim_s));

   role_sync #(.WIDTH(N_UNITS), .STAGES(SYNC_STAGES)) u_sync_up (
      .clk(clk), .rst_n(rst_n), .d(unit_up), .q(up_s));

   generate
      for (genvar i = 0; i < N_UNITS; i++) begin : g_cap
         assign capable[i] = (i < N_CAND);
      end
   endgenerate

   assign elig = claim_s & up_s & capable;

   always_comb begin
      up_cnt = '0;
      for (int i = 0; i < N_UNITS; i++) up_cnt = up_cnt + CNT_W'(up_s[i]);
   end
   assign quorum = (up_cnt >= CNT_W'(2));

   role_pick #(.N_CAND(N_CAND), .ID_W(ID_W), .IDX_W(IDX_W),
               .RESTRICTED(RESTRICTED)) u_pick (
      .elig (elig[N_CAND-1:0]),
      .ids  (node_id[N_CAND*ID_W-1:0]),
      .found(found),
      .best (best));

   role_hold #(.N_UNITS(N_UNITS), .IDX_W(IDX_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .up_s(up_s), .quorum(quorum),
      .found(found), .best(best), .held(held), .holder(holder));

   always_comb begin
      for (int i = 0; i < N_UNITS; i++) begin
         if (!up_s[i])                           role_v[i] = ROLE_OFF;
         else if (held && holder == IDX_W'(i))   role_v[i] = ROLE_MST;
         else                                    role_v[i] = ROLE_CHK;
         role[2*i +: 2] = role_v[i];
         mst_vec[i]     = (role_v[i] == ROLE_MST);
      end
   end

   assign master_valid = held & up_s[holder] & quorum;

   // R2: never two Masters
   p_single_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mst_vec));

   // R2: a valid flag always comes with exactly one Master
   p_valid_has_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
      master_valid |-> ($countones(mst_vec) == 1));

   // R3: the chosen candidate has no eligible rival with a smaller ID
   generate
      for (genvar j = 0; j < N_CAND; j++) begin : g_min_chk
         p_lowest_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (found && elig[j]) |->
               (node_id[best*ID_W +: ID_W] <= node_id[j*ID_W +: ID_W]));
      end
   endgenerate

endmodule

// File: tb/sim_role_arbiter.sv
`timescale 1ns/1ps
module sim_role_arbiter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] claim = '0;
   logic [2:0] up = '0;
   logic [11:0] ids0 = {4'd9, 4'd2, 4'd5};
   logic [11:0] ids1 = {4'd1, 4'd7, 4'd5};
   logic [5:0] role0, role1;
   logic       mv0, mv1;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      int         due;
      int         dut;
      logic [5:0] roles;
      logic       valid;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   role_arbiter #(.RESTRICTED(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .claim_req(claim), .unit_up(up),
      .node_id(ids0), .role(role0), .master_valid(mv0));

   role_arbiter #(.RESTRICTED(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .claim_req(claim), .unit_up(up),
      .node_id(ids1), .role(role1), .master_valid(mv1));

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic push(input int dut, input int after, input logic [5:0] r,
                       input logic v, input string tag);
      exp_t e;
      e.due = cyc + after; e.dut = dut; e.roles = r; e.valid = v; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic drive(input logic [2:0] c, input logic [2:0] u);
      @(negedge clk);
      claim = c;
      up    = u;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compares queued expectations on their due cycle
   always @(negedge clk) begin : monitor
      exp_t e;
      logic [5:0] ar;
      logic av;
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
         e  = q.pop_front();
         ar = (e.dut == 0) ? role0 : role1;
         av = (e.dut == 0) ? mv0 : mv1;
         checks++;
         if (e.due != cyc || ar !== e.roles || av !== e.valid) begin
            fails++;
            $display("FAIL %s dut%0d: role=%b valid=%b expected role=%b valid=%b",
                     e.tag, e.dut, ar, av, e.roles, e.valid);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired (R1 run hung)");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      // R8: reset state
      checks++;
      if (role0 !== 6'b0 || mv0 !== 1'b0 || role1 !== 6'b0 || mv1 !== 1'b0) begin
         fails++;
         $display("FAIL R8 reset: role0=%b mv0=%b role1=%b mv1=%b expected 000000/0",
                  role0, mv0, role1, mv1);
      end
      rst_n = 1'b1;

      // R1: all operational, nobody claims
      drive(3'b000, 3'b111);
      push(0, 1, 6'b000000, 1'b0, "R1 before sync");
      push(0, 2, 6'b010101, 1'b0, "R1 all checkers");
      idle(3);

      // R3: simultaneous claims, lowest ID (unit1, id 2) wins
      drive(3'b111, 3'b111);
      push(0, 2, 6'b010101, 1'b0, "R3 not yet granted");
      push(0, 3, 6'b011001, 1'b1, "R3 lowest id wins");
      idle(4);

      // R5: Master unit1 goes offline
      drive(3'b111, 3'b101);
      push(0, 1, 6'b011001, 1'b1, "R5 before sync");
      push(0, 2, 6'b010001, 1'b0, "R5 holder offline");
      push(0, 3, 6'b010001, 1'b0, "R5 hold cleared");
      push(0, 4, 6'b010010, 1'b1, "R5 regrant to unit0");
      idle(5);

      // R4: unit1 (lower ID) rejoins while claiming
      drive(3'b111, 3'b111);
      push(0, 2, 6'b010110, 1'b1, "R4 rejoin as checker");
      push(0, 6, 6'b010110, 1'b1, "R4 no preemption");
      idle(7);

      // R3: first claimant unit2 wins although unit1 has a lower ID
      drive(3'b100, 3'b110);
      push(0, 2, 6'b010100, 1'b0, "R5 unit0 offline");
      push(0, 4, 6'b100100, 1'b1, "R3 first claimant wins");
      idle(5);

      // R4: late claim by lower-ID unit1 ignored
      drive(3'b110, 3'b110);
      push(0, 6, 6'b100100, 1'b1, "R4 late claim ignored");
      idle(7);

      // R2: quorum lost, holder stays but valid drops
      drive(3'b110, 3'b100);
      push(0, 2, 6'b100000, 1'b0, "R2 quorum lost");
      idle(3);

      drive(3'b000, 3'b000);
      push(0, 2, 6'b000000, 1'b0, "R1 all offline");
      idle(4);

      // R6: single unit claiming gets no mastership
      drive(3'b001, 3'b001);
      push(0, 6, 6'b000001, 1'b0, "R6 lone unit not granted");
      idle(7);

      drive(3'b001, 3'b011);
      push(0, 2, 6'b000101, 1'b0, "R6 quorum just reached");
      push(0, 3, 6'b000110, 1'b1, "R6 granted with quorum");
      idle(4);

      // R7: restricted variant
      drive(3'b000, 3'b000);
      idle(5);
      drive(3'b100, 3'b111);
      push(1, 6, 6'b010101, 1'b0, "R7 incapable claim ignored");
      idle(7);
      drive(3'b111, 3'b111);
      push(1, 3, 6'b010110, 1'b1, "R7 capable lowest id wins");
      idle(5);

      if (q.size() != 0) begin
         fails++;
         $display("FAIL R1 %0d expectations never compared, expected 0", q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule